// File: doc/BRIEF.md
# Host Keyboard and Power-Management Mailbox

This block connects an ISA-style host I/O bus to an embedded controller through two byte-wide mailbox channels. The keyboard channel answers at host addresses 60h (data) and 64h (command/status). The power-management channel answers at 62h and 66h. Each channel holds one byte travelling from the host to the controller and one byte travelling from the controller to the host. A status byte carries a full flag for each buffer. The host writes a byte and then waits for the controller to consume it. In the other direction, the controller posts a byte, and an interrupt tells the host to fetch it.

The controller reaches each channel through a small register port of four registers per channel. It uses this port to move buffer data, set the interrupt enable and the auxiliary routing flag, enable or lock the channel, and move the channel's port pair to another base address. Host strobes are single-cycle and synchronous to the block clock. Both read paths return their data one cycle after the strobe.

Top module: `kbpm_mailbox`

## Requirements
- R1: After reset:
  - both buffer-full flags, the command flag, the interrupt enable and the auxiliary flag are 0;
  - every channel is enabled and unlocked;
  - the keyboard base is 60h and the power-management base is 62h;
  - all interrupt outputs are 0.
- R2: A channel decodes its data port at host address `base` and its command port at `base+4`, with host address bits 9:8 zero. The two channels never affect each other. If both channels decode the same address, the keyboard channel takes the access.
- R3: A decoded host write stores the byte in the input buffer, sets IBF (status bit 1), and sets CMD (status bit 3). CMD becomes 1 for a write to the command port and 0 for a write to the data port.
- R4: A controller read of register 0 returns the input buffer and clears IBF.
- R5: A controller write to register 0 loads the output buffer and sets OBF (status bit 0). A host read of the data port returns the output buffer and clears OBF. A host read of the command port returns the status byte, which carries OBF in bit 0, IBF in bit 1, CMD in bit 3, IE in bit 4 and AUX in bit 5.
- R6: A controller write to register 1 sets IE from bit 4 and AUX from bit 5. AUX exists on the keyboard channel only. The interrupt outputs follow the channel state with one cycle of delay:
  - `irq_kbd` is OBF·IE·!AUX;
  - `irq_aux` is OBF·IE·AUX;
  - `irq_pm` is the power-management channel's OBF·IE.
- R7: When a channel's enable (register 2, bit 0) is 0, host accesses to its ports are not decoded and leave its state unchanged. A host read of those ports then returns FFh.
- R8: A controller write to register 3 relocates the channel's base address. Controller address bit 2 selects the channel (0 keyboard, 1 power management), and bits 1:0 select the register.
- R9: Writing 1 to the lock bit (register 2, bit 1) sets it until reset. While it is set, writes to the enable bit and to register 3 are ignored.
- R10: A controller write to register 0 may fall in the same cycle as a host data-port read. The host then receives the previous output byte, and OBF stays set with the new byte. A host write may fall in the same cycle as a controller read of register 0. The controller then receives the previous input byte, and IBF stays set with the new byte.
- R11: `host_rdata` and `ctl_rdata` are registered and valid in the cycle after the read strobe. `host_rdata` is FFh after a host read that nothing decodes and in every cycle without a decoded read. `ctl_rdata` is 00h in every cycle without a controller read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 10 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, registered |
| irq_kbd | output | 1 | Keyboard data interrupt |
| irq_aux | output | 1 | Auxiliary device interrupt |
| irq_pm | output | 1 | Power-management interrupt |
| ctl_addr | input | 3 | Controller register address: bit 2 selects the channel, bits 1:0 select the register |
| ctl_we | input | 1 | Controller write strobe |
| ctl_re | input | 1 | Controller read strobe |
| ctl_wdata | input | 8 | Controller write data |
| ctl_rdata | output | 8 | Controller read data, registered |

## Verification
Two cases let both sides of a buffer act in the same cycle. In the first, the controller posts a new output byte while the host reads the data port. In the second, the host writes a new input byte while the controller reads register 0. The bench provokes each case by driving both strobes in one cycle through a combined stimulus task. It judges the result with the returned byte, which must be the old value, and the following status read, which must still show the flag set with the new byte. Its behavioural model is also compared on every clock.

// File: rtl/kbpm_pkg.sv
package kbpm_pkg;
  // status byte bit positions
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CMD = 3;
  localparam int ST_IE  = 4;
  localparam int ST_AUX = 5;
  // configuration register bits
  localparam int CFG_EN   = 0;
  localparam int CFG_LOCK = 1;
  // command port sits this far above the data port
  localparam int CMD_OFS = 4;

  typedef enum logic [1:0] {
    REG_BUF  = 2'd0,
    REG_STAT = 2'd1,
    REG_CFG  = 2'd2,
    REG_BASE = 2'd3
  } ctl_reg_e;
endpackage

// File: rtl/kbpm_port_dec.sv
module kbpm_port_dec #(
  parameter int HADDR_W = 10,
  parameter int DW      = 8
) (
  input  logic               en,
  input  logic [DW-1:0]      base,
  input  logic [HADDR_W-1:0] addr,
  output logic               hit_data,
  output logic               hit_cmd
);
  import kbpm_pkg::*;
  localparam int HI_W = HADDR_W - DW;

  logic [DW-1:0] cmd_addr;
  logic          hi_zero;

  always_comb begin
    cmd_addr = base + DW'(CMD_OFS);
    hi_zero  = (addr[HADDR_W-1:DW] == {HI_W{1'b0}});
    hit_data = en && hi_zero && (addr[DW-1:0] == base);
    hit_cmd  = en && hi_zero && (addr[DW-1:0] == cmd_addr);
  end
endmodule

// File: rtl/kbpm_chan.sv
module kbpm_chan #(
  parameter int            DW       = 8,
  parameter bit            HAS_AUX  = 1'b1,
  parameter logic [DW-1:0] RST_BASE = 8'h60
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  hit_data,
  input  logic                  hit_cmd,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [DW-1:0]         host_wdata,
  input  logic                  c_we,
  input  logic                  c_re,
  input  kbpm_pkg::ctl_reg_e    c_reg,
  input  logic [DW-1:0]         c_wdata,
  output logic                  en_o,
  output logic [DW-1:0]         base_o,
  output logic [DW-1:0]         rd_host,
  output logic [DW-1:0]         rd_ctl,
  output logic                  irq_main_o,
  output logic                  irq_aux_o
);
  import kbpm_pkg::*;

  logic [DW-1:0] obuf, ibuf, base;
  logic          obf, ibf, cmd, ie, aux, en, lock;
  logic [DW-1:0] status;
  logic          hit_any;

  assign hit_any = hit_data || hit_cmd;

  always_comb begin
    status         = '0;
    status[ST_OBF] = obf;
    status[ST_IBF] = ibf;
    status[ST_CMD] = cmd;
    status[ST_IE]  = ie;
    status[ST_AUX] = aux;
  end

  always_comb begin
    rd_host = hit_data ? obuf : status;
    case (c_reg)
      REG_BUF:  rd_ctl = ibuf;
      REG_STAT: rd_ctl = status;
      REG_CFG:  begin
        rd_ctl           = '0;
        rd_ctl[CFG_EN]   = en;
        rd_ctl[CFG_LOCK] = lock;
      end
      default:  rd_ctl = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      obuf       <= '0;
      ibuf       <= '0;
      obf        <= 1'b0;
      ibf        <= 1'b0;
      cmd        <= 1'b0;
      ie         <= 1'b0;
      aux        <= 1'b0;
      en         <= 1'b1;
      lock       <= 1'b0;
      base       <= RST_BASE;
      irq_main_o <= 1'b0;
      irq_aux_o  <= 1'b0;
    end else begin
      // controller posting wins over a same-cycle host fetch
      if (c_we && c_reg == REG_BUF) begin
        obuf <= c_wdata;
        obf  <= 1'b1;
      end else if (host_rd && hit_data) begin
        obf <= 1'b0;
      end
      // host posting wins over a same-cycle controller fetch
      if (host_wr && hit_any) begin
        ibuf <= host_wdata;
        ibf  <= 1'b1;
        cmd  <= hit_cmd;
      end else if (c_re && c_reg == REG_BUF) begin
        ibf <= 1'b0;
      end
      if (c_we && c_reg == REG_STAT) begin
        ie  <= c_wdata[ST_IE];
        aux <= HAS_AUX ? c_wdata[ST_AUX] : 1'b0;
      end
      if (c_we && c_reg == REG_CFG) begin
        lock <= lock | c_wdata[CFG_LOCK];
        if (!lock) en <= c_wdata[CFG_EN];
      end
      if (c_we && c_reg == REG_BASE && !lock) base <= c_wdata;
      irq_main_o <= obf && ie && !aux;
      irq_aux_o  <= obf && ie && aux;
    end
  end

  assign en_o   = en;
  assign base_o = base;

  // R5
  obf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (c_we && c_reg == REG_BUF) |=> obf);
  // R3
  ibf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (host_wr && hit_any) |=> (ibf && cmd == $past(hit_cmd)));
  // R9
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lock && c_we && (c_reg == REG_CFG || c_reg == REG_BASE)) |=> ($stable(en) && $stable(base) && lock));
  // R7
  dis_hit_chk: assert property (@(posedge clk) disable iff (rst)
    !en |-> !hit_any);
  // R6
  irq_main_chk: assert property (@(posedge clk) disable iff (rst)
    (obf && ie && !aux) |=> irq_main_o);
  // R10
  post_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (c_we && c_reg == REG_BUF && host_rd && hit_data) |=> obf);
endmodule

// File: rtl/kbpm_mailbox.sv
module kbpm_mailbox #(
  parameter int         HADDR_W  = 10,
  parameter int         DW       = 8,
  parameter logic [7:0] KBD_BASE = 8'h60,
  parameter logic [7:0] PM_BASE  = 8'h62
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [HADDR_W-1:0] host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [DW-1:0]      host_wdata,
  output logic [DW-1:0]      host_rdata,
  output logic               irq_kbd,
  output logic               irq_aux,
  output logic               irq_pm,
  input  logic [2:0]         ctl_addr,
  input  logic               ctl_we,
  input  logic               ctl_re,
  input  logic [DW-1:0]      ctl_wdata,
  output logic [DW-1:0]      ctl_rdata
);
  import kbpm_pkg::*;
  localparam int NCH = 2;
  localparam logic [DW-1:0] FLOAT = {DW{1'b1}};

  logic [NCH-1:0] raw_d, raw_c, hit_d, hit_c, en_v, irq_m, irq_a, c_we, c_re;
  logic [DW-1:0]  base_v  [NCH];
  logic [DW-1:0]  rd_host [NCH];
  logic [DW-1:0]  rd_ctl  [NCH];
  ctl_reg_e       c_reg;

  assign c_reg = ctl_reg_e'(ctl_addr[1:0]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [DW-1:0] RB = (g == 0) ? DW'(KBD_BASE) : DW'(PM_BASE);

    assign c_we[g] = ctl_we && (ctl_addr[2] == 1'(g));
    assign c_re[g] = ctl_re && (ctl_addr[2] == 1'(g));

    kbpm_port_dec #(.HADDR_W(HADDR_W), .DW(DW)) u_dec (
      .en(en_v[g]), .base(base_v[g]), .addr(host_addr),
      .hit_data(raw_d[g]), .hit_cmd(raw_c[g])
    );

    kbpm_chan #(.DW(DW), .HAS_AUX(g == 0), .RST_BASE(RB)) u_chan (
      .clk(clk), .rst(rst),
      .hit_data(hit_d[g]), .hit_cmd(hit_c[g]),
      .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
      .c_we(c_we[g]), .c_re(c_re[g]), .c_reg(c_reg), .c_wdata(ctl_wdata),
      .en_o(en_v[g]), .base_o(base_v[g]),
      .rd_host(rd_host[g]), .rd_ctl(rd_ctl[g]),
      .irq_main_o(irq_m[g]), .irq_aux_o(irq_a[g])
    );
  end

  // lower channel index claims an address both decode
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      hit_d[i] = raw_d[i] && !taken;
      hit_c[i] = raw_c[i] && !taken;
      taken    = taken || raw_d[i] || raw_c[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= FLOAT;
      ctl_rdata  <= '0;
    end else begin
      host_rdata <= FLOAT;
      for (int i = 0; i < NCH; i++)
        if (host_rd && (hit_d[i] || hit_c[i])) host_rdata <= rd_host[i];
      ctl_rdata <= ctl_re ? rd_ctl[ctl_addr[2]] : '0;
    end
  end

  assign irq_kbd = irq_m[0];
  assign irq_aux = irq_a[0];
  assign irq_pm  = irq_m[1] | irq_a[1];

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_d, hit_c}));
  // R11
  float_rd_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> (host_rdata == FLOAT));
endmodule

// File: tb/kbpm_mailbox_tb.sv
module kbpm_mailbox_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] h_addr = '0;
  logic       h_wr = 1'b0, h_rd = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic       irq_kbd, irq_aux, irq_pm;
  logic [2:0] c_addr = '0;
  logic       c_we = 1'b0, c_re = 1'b0;
  logic [7:0] c_wdata = '0;
  logic [7:0] c_rdata;

  int vectors = 0;
  int fails   = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  kbpm_mailbox u_dut (
    .clk(clk), .rst(rst), .host_addr(h_addr), .host_wr(h_wr), .host_rd(h_rd),
    .host_wdata(h_wdata), .host_rdata(h_rdata), .irq_kbd(irq_kbd),
    .irq_aux(irq_aux), .irq_pm(irq_pm), .ctl_addr(c_addr), .ctl_we(c_we),
    .ctl_re(c_re), .ctl_wdata(c_wdata), .ctl_rdata(c_rdata)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_obuf [2], m_ibuf [2], m_base [2];
  bit         m_obf [2], m_ibf [2], m_cmd [2], m_ie [2], m_aux [2], m_en [2], m_lock [2];
  logic [7:0] m_hrd = 8'hFF, m_crd = 8'h00;
  bit         m_irq_k = 0, m_irq_a = 0, m_irq_p = 0;

  function automatic logic [7:0] m_stat(int ch);
    return {2'b00, m_aux[ch], m_ie[ch], m_cmd[ch], 1'b0, m_ibf[ch], m_obf[ch]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        m_obuf[i] = 0; m_ibuf[i] = 0; m_obf[i] = 0; m_ibf[i] = 0; m_cmd[i] = 0;
        m_ie[i] = 0; m_aux[i] = 0; m_en[i] = 1; m_lock[i] = 0;
      end
      m_base[0] = 8'h60; m_base[1] = 8'h62;
      m_hrd = 8'hFF; m_crd = 8'h00; m_irq_k = 0; m_irq_a = 0; m_irq_p = 0;
    end else begin
      bit hd [2], hc [2];
      int ch;
      for (int i = 0; i < 2; i++) begin
        hd[i] = m_en[i] && h_addr[9:8] == 0 && h_addr[7:0] == m_base[i];
        hc[i] = m_en[i] && h_addr[9:8] == 0 && h_addr[7:0] == 8'(m_base[i] + 4);
      end
      if (hd[0] || hc[0]) begin hd[1] = 0; hc[1] = 0; end
      m_hrd = 8'hFF;
      for (int i = 0; i < 2; i++) begin
        if (h_rd && hd[i]) m_hrd = m_obuf[i];
        if (h_rd && hc[i]) m_hrd = m_stat(i);
      end
      ch = c_addr[2];
      if (c_re) begin
        case (c_addr[1:0])
          2'd0: m_crd = m_ibuf[ch];
          2'd1: m_crd = m_stat(ch);
          2'd2: m_crd = {6'd0, m_lock[ch], m_en[ch]};
          default: m_crd = m_base[ch];
        endcase
      end else m_crd = 8'h00;
      m_irq_k = m_obf[0] && m_ie[0] && !m_aux[0];
      m_irq_a = m_obf[0] && m_ie[0] && m_aux[0];
      m_irq_p = m_obf[1] && m_ie[1];
      for (int i = 0; i < 2; i++) begin
        bit we_i, re_i;
        we_i = c_we && ch == i;
        re_i = c_re && ch == i;
        if (we_i && c_addr[1:0] == 0) begin m_obuf[i] = c_wdata; m_obf[i] = 1; end
        else if (h_rd && hd[i]) m_obf[i] = 0;
        if (h_wr && (hd[i] || hc[i])) begin m_ibuf[i] = h_wdata; m_ibf[i] = 1; m_cmd[i] = hc[i]; end
        else if (re_i && c_addr[1:0] == 0) m_ibf[i] = 0;
        if (we_i && c_addr[1:0] == 1) begin m_ie[i] = c_wdata[4]; m_aux[i] = (i == 0) && c_wdata[5]; end
        if (we_i && c_addr[1:0] == 2) begin
          if (!m_lock[i]) m_en[i] = c_wdata[0];
          m_lock[i] = m_lock[i] || c_wdata[1];
        end
        if (we_i && c_addr[1:0] == 3 && !m_lock[i]) m_base[i] = c_wdata;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      vectors++;
      if ({h_rdata, c_rdata, irq_kbd, irq_aux, irq_pm} !== {m_hrd, m_crd, m_irq_k, m_irq_a, m_irq_p}) begin
        fails++;
        $display("FAIL model R1-R11 cycle %0d: actual %h/%h/%b%b%b expected %h/%h/%b%b%b", cycles,
          h_rdata, c_rdata, irq_kbd, irq_aux, irq_pm, m_hrd, m_crd, m_irq_k, m_irq_a, m_irq_p);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input bit hw, input bit hr, input logic [9:0] ha, input logic [7:0] hd,
                      input bit cw, input bit cr, input logic [2:0] ca, input logic [7:0] cd);
    h_wr = hw; h_rd = hr; h_addr = ha; h_wdata = hd;
    c_we = cw; c_re = cr; c_addr = ca; c_wdata = cd;
    @(negedge clk);
    h_wr = 0; h_rd = 0; c_we = 0; c_re = 0;
  endtask

  task automatic hw(input logic [9:0] a, input logic [7:0] d); step(1, 0, a, d, 0, 0, 0, 0); endtask
  task automatic hr(input logic [9:0] a); step(0, 1, a, 0, 0, 0, 0, 0); endtask
  task automatic cw(input logic [2:0] a, input logic [7:0] d); step(0, 0, 0, 0, 1, 0, a, d); endtask
  task automatic cr(input logic [2:0] a); step(0, 0, 0, 0, 0, 1, a, 0); endtask
  task automatic idle(input int n); for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0); endtask

  task automatic do_reset;
    rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  initial begin
    do_reset;
    // R1 reset state
    chk("R1 irqs", {5'd0, irq_kbd, irq_aux, irq_pm}, 8'h00);
    cr(3'b010); chk("R1 kbd cfg", c_rdata, 8'h01);
    cr(3'b011); chk("R1 kbd base", c_rdata, 8'h60);
    cr(3'b111); chk("R1 pm base", c_rdata, 8'h62);
    hr(10'h300); chk("R11 undecoded read", h_rdata, 8'hFF);
    idle(1); chk("R11 ctl idle", c_rdata, 8'h00);
    // R3 / R4
    hw(10'h060, 8'hA5); cr(3'b001); chk("R3 data write status", c_rdata, 8'h02);
    cr(3'b000); chk("R4 ibuf read", c_rdata, 8'hA5);
    cr(3'b001); chk("R4 ibf cleared", c_rdata, 8'h00);
    hw(10'h064, 8'hD4); cr(3'b001); chk("R3 cmd write status", c_rdata, 8'h0A);
    cr(3'b000); chk("R4 cmd byte", c_rdata, 8'hD4);
    // R2 power-management ports
    hw(10'h066, 8'h81); cr(3'b101); chk("R2 pm cmd status", c_rdata, 8'h0A);
    cr(3'b001); chk("R2 kbd untouched", c_rdata, 8'h08);
    cr(3'b100); chk("R2 pm ibuf", c_rdata, 8'h81);
    hw(10'h062, 8'h42); cr(3'b101); chk("R2 pm data status", c_rdata, 8'h02);
    cr(3'b100); chk("R2 pm data byte", c_rdata, 8'h42);
    // R5
    cw(3'b000, 8'h3C); hr(10'h064); chk("R5 status obf", h_rdata, 8'h09);
    hr(10'h060); chk("R5 data read", h_rdata, 8'h3C);
    hr(10'h064); chk("R5 obf cleared", h_rdata, 8'h08);
    // R6 interrupts
    cw(3'b001, 8'h10); cw(3'b000, 8'h11);
    chk("R6 irq latency", {7'd0, irq_kbd}, 8'h00);
    idle(1); chk("R6 irq_kbd set", {7'd0, irq_kbd}, 8'h01);
    hr(10'h060); idle(1); chk("R6 irq_kbd cleared", {7'd0, irq_kbd}, 8'h00);
    cw(3'b001, 8'h30); cw(3'b000, 8'h22); idle(1);
    chk("R6 aux routing", {6'd0, irq_kbd, irq_aux}, 8'h01);
    hr(10'h064); chk("R6 aux status", h_rdata, 8'h39);
    hr(10'h060); cw(3'b001, 8'h10);
    cw(3'b101, 8'h10); cw(3'b100, 8'h5A); idle(1);
    chk("R6 irq_pm set", {7'd0, irq_pm}, 8'h01);
    hr(10'h062); chk("R6 pm data", h_rdata, 8'h5A);
    idle(1); chk("R6 irq_pm cleared", {7'd0, irq_pm}, 8'h00);
    // R8 relocation
    cw(3'b011, 8'h70); cr(3'b011); chk("R8 base reg", c_rdata, 8'h70);
    hw(10'h060, 8'h01); cr(3'b001); chk("R8 old port dead", c_rdata, 8'h18);
    hw(10'h070, 8'h02); hr(10'h074); chk("R8 new cmd port", h_rdata, 8'h12);
    cr(3'b000); chk("R8 new data port", c_rdata, 8'h02);
    // R7 disable
    cw(3'b110, 8'h00); hw(10'h066, 8'h33); cr(3'b101); chk("R7 disabled write", c_rdata, 8'h10);
    cw(3'b100, 8'h44); hr(10'h062); chk("R7 disabled read", h_rdata, 8'hFF);
    cw(3'b110, 8'h01); hr(10'h062); chk("R7 re-enabled read", h_rdata, 8'h44);
    // R9 lock
    cw(3'b110, 8'h03); cw(3'b110, 8'h00); cr(3'b110); chk("R9 enable locked", c_rdata, 8'h03);
    cw(3'b111, 8'h90); cr(3'b111); chk("R9 base locked", c_rdata, 8'h62);
    hw(10'h066, 8'h7E); cr(3'b100); chk("R9 still decodes", c_rdata, 8'h7E);
    // R10 collisions
    cw(3'b000, 8'h55);
    step(0, 1, 10'h070, 0, 1, 0, 3'b000, 8'hAA); chk("R10 host gets old", h_rdata, 8'h55);
    cr(3'b001); chk("R10 obf kept", c_rdata, 8'h11);
    hr(10'h070); chk("R10 new byte", h_rdata, 8'hAA);
    hw(10'h070, 8'h77);
    step(1, 0, 10'h070, 8'h99, 0, 1, 3'b000, 0); chk("R10 ctl gets old", c_rdata, 8'h77);
    cr(3'b001); chk("R10 ibf kept", c_rdata, 8'h12);
    cr(3'b000); chk("R10 new input", c_rdata, 8'h99);
    // R9 lock released by reset, R1 bases restored
    do_reset;
    cr(3'b110); chk("R9 lock cleared", c_rdata, 8'h01);
    cr(3'b011); chk("R1 kbd base again", c_rdata, 8'h60);
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule